// File: doc/BRIEF.md
# TDM Frame Serializer

This block turns parallel bytes into one serial time-division-multiplexed bit stream. It runs on a single bit clock. Each frame has 32 time slots of 8 bits each, so a frame is 256 bit times long. At the nominal 2.048 MHz bit rate, frames repeat 8000 times per second, and each frame lasts 125 microseconds.

The block tells the byte source which slot it wants next through a 5-bit slot index. The source places that slot's byte on the parallel input. On the clock edge that ends the last bit of the current slot, the block copies the byte into a shift register. It then sends the byte most significant bit first, one bit per clock. A one-bit frame marker goes high for the single bit time that carries the first bit of slot 0.

Top module: `tdm_frame_tx`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is: `sync_out`=1, `ser_out`=0, `slot_idx`=1. Position 0 of the first frame follows that reset state. The first slot after reset carries the byte 0x00, because no byte has been loaded yet.
- R2: `sync_out` is 1 in exactly one bit time per frame. That bit time is the first bit (position 0) of slot 0. In the other 255 bit times, `sync_out` is 0.
- R3: Each slot sends its byte most significant bit first. Bit 7 goes out in the slot's first bit time and bit 0 in its eighth. Each bit lasts exactly one clock.
- R4: `byte_in` is sampled only on the edge that ends bit time 7 of a slot. From the next bit time on, the sampled byte is sent as the following slot.
- R5: During slot s, `slot_idx` equals (s+1) mod 32. It therefore names the slot whose byte is captured at the end of slot s, and it wraps from 31 to 0.
- R6: A frame is 256 bit times long, made of 32 slots of 8 bits. Successive `sync_out` pulses are exactly 256 clocks apart.
- R7: A value on `byte_in` during bit times 0 to 6 of a slot has no effect on `ser_out`.
- R8: A reset applied in the middle of a frame restarts the framing from position 0, as described in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| byte_in | input | 8 | Byte for the slot named by `slot_idx` |
| slot_idx | output | 5 | Slot whose byte is captured at the end of the current slot |
| ser_out | output | 1 | Serial data, most significant bit first |
| sync_out | output | 1 | Frame marker, high in the first bit time of slot 0 |

## Verification
All three outputs are registers, so each one shows the state reached at the latest rising edge. A byte presented during bit time 7 of a slot appears on `ser_out` as bit 7 one clock later. A frame marker is due exactly 256 clocks after the previous one. After a reset edge, the reset values are due at once, and the first counted position follows one edge after `rst` falls. The bench drives the inputs and samples the outputs on falling edges. On every clock it compares all three outputs with a behavioural position and byte model, and it drives junk values on `byte_in` outside bit time 7 to check R7.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int unsigned SLOT_WIDTH = 8;
  localparam int unsigned SLOTS_PER_FRAME = 32;

  function automatic int unsigned cw(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int unsigned SLOT_W = tdm_tx_pkg::SLOT_WIDTH,
  parameter int unsigned NUM_SLOTS = tdm_tx_pkg::SLOTS_PER_FRAME,
  localparam int unsigned BIT_CW = tdm_tx_pkg::cw(SLOT_W),
  localparam int unsigned SLOT_CW = tdm_tx_pkg::cw(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  output logic               load_o,
  output logic               sync_o,
  output logic [SLOT_CW-1:0] next_slot_o
);
  localparam logic [BIT_CW-1:0]  LAST_BIT  = BIT_CW'(SLOT_W - 1);
  localparam logic [SLOT_CW-1:0] LAST_SLOT = SLOT_CW'(NUM_SLOTS - 1);
  localparam logic [SLOT_CW-1:0] FIRST_NEXT = (NUM_SLOTS > 1) ? SLOT_CW'(1) : '0;

  logic [BIT_CW-1:0]  bit_cnt;
  logic [SLOT_CW-1:0] slot_cnt;
  logic [SLOT_CW-1:0] next_slot_q;
  logic               sync_q;
  logic               last_bit;
  logic               frame_end;

  assign last_bit  = (bit_cnt == LAST_BIT);
  assign frame_end = last_bit && (slot_cnt == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt     <= '0;
      slot_cnt    <= '0;
      next_slot_q <= FIRST_NEXT;
      sync_q      <= 1'b1;
    end else begin
      sync_q <= frame_end;
      if (last_bit) begin
        bit_cnt     <= '0;
        slot_cnt    <= (slot_cnt == LAST_SLOT) ? '0 : slot_cnt + 1'b1;
        next_slot_q <= (next_slot_q == LAST_SLOT) ? '0 : next_slot_q + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign load_o      = last_bit;
  assign sync_o      = sync_q;
  assign next_slot_o = next_slot_q;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (sync_q && bit_cnt == '0 && slot_cnt == '0));

  p_sync_single_r2: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> !sync_q);

  p_sync_origin_r2: assert property (@(posedge clk) disable iff (rst)
    sync_q |-> (bit_cnt == '0 && slot_cnt == '0));

  p_slot_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !last_bit |=> $stable(slot_cnt));

  p_slot_ahead_r5: assert property (@(posedge clk) disable iff (rst)
    next_slot_q == ((slot_cnt == LAST_SLOT) ? '0 : slot_cnt + 1'b1));
endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter #(
  parameter int unsigned SLOT_W = tdm_tx_pkg::SLOT_WIDTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] data_i,
  output logic              ser_o
);
  logic [SLOT_W-1:0] shreg;

  generate
    if (SLOT_W > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)         shreg <= '0;
        else if (load_i) shreg <= data_i;
        else             shreg <= {shreg[SLOT_W-2:0], 1'b0};
      end

      p_shift_msb_first_r3: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> shreg[SLOT_W-1] == $past(shreg[SLOT_W-2]));
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)         shreg <= '0;
        else if (load_i) shreg <= data_i;
      end
    end
  endgenerate

  assign ser_o = shreg[SLOT_W-1];

  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> shreg == $past(data_i));
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
  parameter int unsigned SLOT_W = tdm_tx_pkg::SLOT_WIDTH,
  parameter int unsigned NUM_SLOTS = tdm_tx_pkg::SLOTS_PER_FRAME,
  localparam int unsigned SLOT_CW = tdm_tx_pkg::cw(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SLOT_W-1:0]  byte_in,
  output logic [SLOT_CW-1:0] slot_idx,
  output logic               ser_out,
  output logic               sync_out
);
  logic load;

  tdm_slot_timer #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_o     (load),
    .sync_o     (sync_out),
    .next_slot_o(slot_idx)
  );

  tdm_shifter #(.SLOT_W(SLOT_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .data_i(byte_in),
    .ser_o (ser_out)
  );

  p_idx_changes_at_load_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(slot_idx));
endmodule

// File: tb/test_tdm_frame_tx.sv
module test_tdm_frame_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byte_in = 8'h00;
  logic [4:0] slot_idx;
  logic       ser_out;
  logic       sync_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int         pos;
  logic [7:0] cur;
  int         frame;
  int         cyc;
  int         last_sync_cyc;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  tdm_frame_tx i_tdm_frame_tx (
    .clk(clk), .rst(rst), .byte_in(byte_in),
    .slot_idx(slot_idx), .ser_out(ser_out), .sync_out(sync_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  function automatic logic [7:0] pattern(input int mode, input int slot, input int frm);
    case (mode)
      0: return 8'((slot * 8 + 3) ^ frm);
      1: return (slot % 2 == 1) ? 8'hFF : 8'h00;
      2: return 8'(8'h01 << (slot % 8)) | ((slot % 3 == 0) ? 8'h80 : 8'h00);
      default: return step_lfsr();
    endcase
  endfunction

  task automatic model_reset();
    pos = 0;
    cur = 8'h00;
    last_sync_cyc = -1;
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      int bit_pos;
      int nslot;
      logic [7:0] drv;
      bit_pos = pos % 8;
      nslot = (pos / 8 + 1) % 32;
      chk("R3 R4 R7 ser_out", int'(ser_out), int'(cur[7 - bit_pos]));
      chk("R2 sync_out", int'(sync_out), (pos == 0) ? 1 : 0);
      chk("R5 slot_idx", int'(slot_idx), nslot);
      if (sync_out) begin
        if (last_sync_cyc >= 0) chk("R6 frame length", cyc - last_sync_cyc, 256);
        last_sync_cyc = cyc;
      end
      if (bit_pos == 7) drv = pattern(mode, nslot, frame);
      else if (mode == 0) drv = 8'h00;
      else drv = step_lfsr();
      byte_in = drv;
      @(posedge clk);
      if (bit_pos == 7) cur = drv;
      pos = (pos + 1) % 256;
      if (pos == 0) frame++;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic apply_reset(input int n, input string req);
    rst = 1'b1;
    byte_in = step_lfsr();
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    chk({req, " reset sync_out"}, int'(sync_out), 1);
    chk({req, " reset ser_out"}, int'(ser_out), 0);
    chk({req, " reset slot_idx"}, int'(slot_idx), 1);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    cyc = 0;
    frame = 0;
    model_reset();
    @(negedge clk);
    apply_reset(3, "R1");
    run(600, 0);
    run(520, 1);
    run(300, 2);
    apply_reset(2, "R8");
    run(700, 3);
    run(256 * 3, 2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule